// File: doc/BRIEF.md
# Double-Buffered Endpoint Transmit Interrupt

This block keeps the state of a two-layer transmit buffer that belongs to one IN endpoint of a USB device controller. The local microcontroller loads one layer at a time. It then pulses a commit strobe, which marks that layer as full and moves the write pointer to the other layer. The serial interface engine always sends the oldest full layer when an IN token arrives. A layer becomes free again only after the host has returned ACK for its packet. When a handshake is missing, the same layer stays full and is sent again on the next token. When no layer is full, the engine is told to answer with NAK.

The block drives a level-sensitive, active-high packet-ready interrupt from the registered layer flags. It has two run-time controls: an enable and a mode bit. With the mode bit at 0, the interrupt asks for data whenever at least one layer is free. With the mode bit at 1, it asks only when both layers are free. The chip-level interrupt output is the OR of this term with the other interrupt sources. Reconfiguring the endpoint or a bus reset empties both layers and returns both pointers to layer 0 in one cycle.

Top module: `ep_txpp_irq`

## Requirements
- R1: After reset, both layer-full flags are 0, and both the write and read pointers point to layer 0.
- R2: A commit strobe while the layer under the write pointer is empty sets that layer's full flag (bit 0 of `layer_full` is layer 0, bit 1 is layer 1) and toggles the write pointer on the next clock. A commit while that layer is already full has no effect.
- R3: An IN token while the layer under the read pointer is full raises `send_valid` in the same cycle, with `send_layer` equal to the oldest committed layer.
- R4: An IN token while no layer is full raises `nak` in the same cycle, and `send_valid` stays low.
- R5: An ACK while the layer under the read pointer is full clears that layer's flag and toggles the read pointer on the next clock. An ACK while no layer is full has no effect.
- R6: Without an ACK, the read pointer and the full flags do not change, so the next IN token sends the same layer again.
- R7: While `irq_en` is 0, `ep_irq` is 0 whatever the layer state.
- R8: With `irq_en`=1 and `irq_both`=0, `ep_irq` is 1 when at least one layer is empty, and 0 only when both layers are full.
- R9: With `irq_en`=1 and `irq_both`=1, `ep_irq` is 1 only when both layers are empty.
- R10: A change of `irq_en` or `irq_both` changes `ep_irq` in the same cycle, with no clock needed.
- R11: `irq_out` equals `ep_irq` OR `other_irq`.
- R12: `cfg_clear` empties both layers and sets both pointers to layer 0 on the next clock. It overrides a commit or an ACK in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clear | input | 1 | Endpoint reconfiguration or bus reset; empties the buffer |
| mcu_commit | input | 1 | Microcontroller marks the current write layer as ready |
| sie_in_token | input | 1 | IN token received for this endpoint |
| sie_ack | input | 1 | Host returned ACK for the packet just sent |
| irq_en | input | 1 | Packet-ready interrupt enable |
| irq_both | input | 1 | 0: interrupt when any layer is empty; 1: only when both are empty |
| other_irq | input | 1 | OR of the chip's other interrupt sources |
| layer_full | output | 2 | Full flag for each layer |
| wr_layer | output | 1 | Layer the microcontroller fills next |
| rd_layer | output | 1 | Oldest layer, the next to be sent |
| send_valid | output | 1 | Send the packet from `send_layer` for this token |
| send_layer | output | 1 | Layer to send |
| nak | output | 1 | Answer this token with NAK |
| ep_irq | output | 1 | Endpoint packet-ready interrupt term |
| irq_out | output | 1 | Chip-level interrupt, active high |

## Verification
The hardest state to reach from the ports is a buffer with both layers full and the pointers wrapped past layer 1. In that state a commit and an ACK arrive in the same cycle, or a mode change comes while exactly one layer is full. A directed sequence fills both layers, drains one, refills it and then toggles `irq_both` to cover those cases. After that, a long run with weighted random strobes keeps the buffer moving through every occupancy and pointer pair. A queue-based model in the bench is checked against all outputs on every cycle.

// File: rtl/ep_txpp_irq.sv
module ep_txpp_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_clear,
  input  logic       mcu_commit,
  input  logic       sie_in_token,
  input  logic       sie_ack,
  input  logic       irq_en,
  input  logic       irq_both,
  input  logic       other_irq,
  output logic [1:0] layer_full,
  output logic       wr_layer,
  output logic       rd_layer,
  output logic       send_valid,
  output logic       send_layer,
  output logic       nak,
  output logic       ep_irq,
  output logic       irq_out
);

  logic [1:0] full_q, full_d;
  logic       wp_q, rp_q;
  logic       do_fill, do_free;

  assign do_fill = mcu_commit & ~full_q[wp_q];
  assign do_free = sie_ack & full_q[rp_q];

  always_comb begin
    full_d = full_q;
    if (do_fill) full_d[wp_q] = 1'b1;
    if (do_free) full_d[rp_q] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 2'b00;
      wp_q   <= 1'b0;
      rp_q   <= 1'b0;
    end else if (cfg_clear) begin
      full_q <= 2'b00;
      wp_q   <= 1'b0;
      rp_q   <= 1'b0;
    end else begin
      full_q <= full_d;
      if (do_fill) wp_q <= ~wp_q;
      if (do_free) rp_q <= ~rp_q;
    end
  end

  assign layer_full = full_q;
  assign wr_layer   = wp_q;
  assign rd_layer   = rp_q;
  assign send_layer = rp_q;
  assign send_valid = sie_in_token & full_q[rp_q];
  assign nak        = sie_in_token & ~full_q[rp_q];
  assign ep_irq     = irq_en & (irq_both ? ~|full_q : ~&full_q);
  assign irq_out    = ep_irq | other_irq;

endmodule

module ep_txpp_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_clear,
  input logic       mcu_commit,
  input logic       sie_in_token,
  input logic       sie_ack,
  input logic       irq_en,
  input logic       irq_both,
  input logic       other_irq,
  input logic [1:0] layer_full,
  input logic       wr_layer,
  input logic       rd_layer,
  input logic       send_valid,
  input logic       send_layer,
  input logic       nak,
  input logic       ep_irq,
  input logic       irq_out
);

  // R2
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_commit && !layer_full[wr_layer] && !cfg_clear) |=>
      (layer_full[$past(wr_layer)] && wr_layer != $past(wr_layer)));

  // R5
  free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_ack && layer_full[rd_layer] && !cfg_clear) |=>
      (!layer_full[$past(rd_layer)] && rd_layer != $past(rd_layer)));

  // R6
  hold_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sie_ack && !cfg_clear) |=> $stable(rd_layer));

  // R12
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> (layer_full == 2'b00 && !wr_layer && !rd_layer));

  // R4
  nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_in_token && layer_full == 2'b00) |-> (nak && !send_valid));

  // R9
  both_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_both && layer_full != 2'b00) |-> !ep_irq);

  // R3
  token_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sie_in_token |-> $onehot({send_valid, nak}));

endmodule

bind ep_txpp_irq ep_txpp_irq_chk u_chk (.*);

// File: tb/ep_txpp_irq_tb.sv
module ep_txpp_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_clear = 0, mcu_commit = 0, sie_in_token = 0, sie_ack = 0;
  logic irq_en = 0, irq_both = 0, other_irq = 0;
  logic [1:0] layer_full;
  logic wr_layer, rd_layer, send_valid, send_layer, nak, ep_irq, irq_out;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  int pend[$];
  int m_wp = 0;
  int m_rd = 0;

  always #4 clk = ~clk;

  ep_txpp_irq u_dut (.*);

  task automatic chk(input string req, input string nm, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  function automatic bit m_full(input int l);
    foreach (pend[i]) if (pend[i] == l) return 1'b1;
    return 1'b0;
  endfunction

  task automatic compare();
    int nfull;
    int exp_irq;
    int exp_full;
    int head;
    nfull    = pend.size();
    exp_full = (m_full(1) ? 2 : 0) + (m_full(0) ? 1 : 0);
    head     = (nfull > 0) ? pend[0] : m_rd;
    if (!irq_en) exp_irq = 0;
    else if (irq_both) exp_irq = (nfull == 0);
    else exp_irq = (nfull < 2);
    chk("R2/R5/R12", "layer_full", layer_full, exp_full);
    chk("R2", "wr_layer", wr_layer, m_wp);
    chk("R6", "rd_layer", rd_layer, head);
    chk("R3", "send_valid", send_valid, (sie_in_token && nfull > 0) ? 1 : 0);
    if (sie_in_token && nfull > 0) chk("R3", "send_layer", send_layer, pend[0]);
    chk("R4", "nak", nak, (sie_in_token && nfull == 0) ? 1 : 0);
    chk("R7/R8/R9/R10", "ep_irq", ep_irq, exp_irq);
    chk("R11", "irq_out", irq_out, (exp_irq != 0 || other_irq) ? 1 : 0);
  endtask

  task automatic update();
    bit fill, free;
    if (cfg_clear) begin
      pend.delete(); m_wp = 0; m_rd = 0;
      return;
    end
    fill = mcu_commit && !m_full(m_wp);
    free = sie_ack && pend.size() > 0;
    if (free) begin
      m_rd = 1 - pend[0];
      void'(pend.pop_front());
    end
    if (fill) begin
      pend.push_back(m_wp);
      m_wp = 1 - m_wp;
    end
  endtask

  task automatic step(input bit clr, input bit cm, input bit tk, input bit ak,
                      input bit en, input bit bo, input bit ot);
    @(negedge clk);
    cfg_clear = clr; mcu_commit = cm; sie_in_token = tk; sie_ack = ak;
    irq_en = en; irq_both = bo; other_irq = ot;
    #1 compare();
    @(posedge clk);
    update();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    #1 compare();
    rst_n = 1'b1;
    // R4 NAK on empty, R7 disabled
    step(0,0,1,0,0,0,0);
    // R8: mode 0 with empty buffer
    step(0,0,0,0,1,0,0);
    // R5: ack with nothing full is ignored
    step(0,0,0,1,1,0,0);
    // R2: fill layer 0, then layer 1
    step(0,1,0,0,1,0,0);
    // R10: one layer full, toggle mode both ways
    step(0,0,0,0,1,1,0);
    step(0,0,0,0,1,0,0);
    step(0,1,0,0,1,0,0);
    // R2: commit while full is ignored, R8 irq low when both full
    step(0,1,0,0,1,0,0);
    // R6: token without ack resends same layer
    step(0,0,1,0,1,0,0);
    step(0,0,1,0,1,0,0);
    // R3/R5: ack frees oldest
    step(0,0,1,1,1,0,0);
    // commit and ack in the same cycle
    step(0,1,1,1,1,1,0);
    step(0,0,1,1,1,1,1);
    step(0,0,1,1,1,1,0);
    // R9: both empty in mode 1
    step(0,0,0,0,1,1,0);
    // R12: clear overriding commit with layers full
    step(0,1,0,0,1,0,0);
    step(0,1,0,0,1,0,0);
    step(1,1,0,1,1,0,0);
    step(0,0,0,0,1,1,1);
    // R11 and weighted random traffic
    for (int i = 0; i < 5000; i++) begin
      step(($urandom % 97) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
           ($urandom % 4) == 0, ($urandom % 8) != 0, ($urandom % 2) == 1,
           ($urandom % 5) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule